// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit nanosecond time base for precision time protocol work. On every enabled reference clock cycle a 32-bit phase accumulator adds a programmable addend; each carry out of the accumulator advances a raw nanosecond count by a programmable tick period. Software trims the clock rate in fine steps by changing the addend. For a nominal rate the addend is ceil(2^32 x nominal_freq / reference_freq).

The reported time is the raw count plus a separately writable 64-bit offset. Software reaches all state through a 32-bit register bus. A 64-bit value is split into a low and a high word. Reading the low word freezes the matching high word, so a later high read gives a coherent pair. Writing the low word only stages it, and the high-word write commits both halves at once.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the raw count, the offset, the accumulator, the enable bit, the tick period and the addend are all zero, and every register reads zero.
- R2: Each enabled cycle the accumulator becomes (accumulator + addend) mod 2^32. A carry out of that sum advances the raw count by the tick period in the same cycle.
- R3: The raw count changes only on an accumulator carry or a count write. An addend of zero never advances it, and an addend of 0x8000_0000 advances it by one period every second cycle.
- R4: Address 0 is the control register, with bit 0 the enable and bits 15:8 the tick period in nanoseconds. While the enable is 0, the accumulator and the raw count hold their values.
- R5: A write to address 2 stages the low count word and leaves the count unchanged. A write to address 3 loads {data, staged low} into the count, also while disabled, and this load takes priority over a same-cycle advance.
- R6: Reading address 2 returns the live low count word and freezes the high count word at that moment. Reading address 3 returns the frozen high word. Reading address 6 does the same for the reported time, and address 7 returns its frozen high word.
- R7: Addresses 4 (low, staged) and 5 (high, commits) write the 64-bit offset, and both read back. time_o always equals raw count + offset modulo 2^64.
- R8: Address 1 holds the addend. A write to it in a cycle that also accumulates still uses the old addend for that cycle, and the new addend applies from the next cycle.
- R9: Writes to addresses 6, 7 and 8 to 15 change nothing, and reads from addresses 8 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 write, 0 read |
| bus_addr_i | input | 4 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of a read request |
| raw_count_o | output | 64 | Raw nanosecond count |
| time_o | output | 64 | Reported time, raw count plus offset |

## Verification
A behavioural model tracks the accumulator, count, offset and frozen words each cycle. It is compared with both 64-bit outputs on every clock, so addend and period changes are tried under zero, half-scale, quarter-scale and near-full-scale addends. The zero addend separates carry-gated counting from free counting. The half-scale addend fixes the exact advance per window, and the near-full-scale addend makes the count step on almost every cycle. Directed sequences then stage a low word alone, commit counts while disabled, move the count across a word boundary between the low and high reads to show the frozen high word, and write to read-only or unmapped addresses.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned PERIOD_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 4'd0,
    A_ADDEND  = 4'd1,
    A_CNT_LO  = 4'd2,
    A_CNT_HI  = 4'd3,
    A_OFF_LO  = 4'd4,
    A_OFF_HI  = 4'd5,
    A_TIME_LO = 4'd6,
    A_TIME_HI = 4'd7
  } reg_addr_e;
endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
  import ptp_tc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 8,
  localparam int unsigned WIDE_W  = 2 * DATA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic                en_o,
  output logic [PERIOD_W-1:0] period_o,
  output logic [DATA_W-1:0]   addend_o,
  output logic [WIDE_W-1:0]   offset_o,
  output logic                cnt_load_o,
  output logic [WIDE_W-1:0]   cnt_load_val_o
);
  logic [DATA_W-1:0] cnt_stage_q, off_stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o        <= 1'b0;
      period_o    <= '0;
      addend_o    <= '0;
      offset_o    <= '0;
      cnt_stage_q <= '0;
      off_stage_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        A_CTRL: begin
          en_o     <= wdata_i[EN_BIT];
          period_o <= wdata_i[PERIOD_LSB +: PERIOD_W];
        end
        A_ADDEND: addend_o    <= wdata_i;
        A_CNT_LO: cnt_stage_q <= wdata_i;
        A_OFF_LO: off_stage_q <= wdata_i;
        A_OFF_HI: offset_o    <= {wdata_i, off_stage_q};
        default: ;
      endcase
    end
  end

  assign cnt_load_o     = wr_i && (addr_i == A_CNT_HI);
  assign cnt_load_val_o = {wdata_i, cnt_stage_q};

  // R8: addend register updates one edge after the write
  a_r8_addend_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ADDEND) |=> addend_o == $past(wdata_i));
  // R7: offset only moves on a high-word commit
  a_r7_offset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_OFF_HI) |=> $stable(offset_o));
endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [ACC_W-1:0] addend_i,
  output logic             carry_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, addend_i};
  assign carry_o = en_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= sum[ACC_W-1:0];
  end

  a_r4_acc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_q));
  a_r2_acc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc_q == ACC_W'($past(acc_q) + $past(addend_i)));
endmodule

// File: rtl/ptp_tc_counter.sv
module ptp_tc_counter #(
  parameter int unsigned CNT_W    = 64,
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                load_i,
  input  logic [CNT_W-1:0]    load_val_i,
  output logic [CNT_W-1:0]    count_o
);
  logic [CNT_W-1:0] period_ext;
  assign period_ext = {{(CNT_W-PERIOD_W){1'b0}}, period_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_o <= '0;
    else if (load_i) count_o <= load_val_i;
    else if (step_i) count_o <= count_o + period_ext;
  end

  a_r5_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> count_o == $past(load_val_i));
  a_r2_step_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i) |=> count_o == $past(count_o) + $past(period_ext));
  a_r3_no_step_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(count_o));
endmodule

// File: rtl/ptp_tc_snap.sv
module ptp_tc_snap #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned WIDE_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic [WIDE_W-1:0] value_i,
  output logic [DATA_W-1:0] lo_o,
  output logic [DATA_W-1:0] hi_o
);
  assign lo_o = value_i[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hi_o <= '0;
    else if (sample_i) hi_o <= value_i[WIDE_W-1:DATA_W];
  end

  a_r6_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |=> hi_o == $past(value_i[WIDE_W-1:DATA_W]));
  a_r6_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(hi_o));
endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_tc_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PERIOD_W = 8,
  localparam int unsigned WIDE_W  = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [WIDE_W-1:0] raw_count_o,
  output logic [WIDE_W-1:0] time_o
);
  localparam int unsigned N_SNAP = 2;

  logic                wr, rd, en, carry, cnt_load;
  logic [PERIOD_W-1:0] period;
  logic [DATA_W-1:0]   addend;
  logic [WIDE_W-1:0]   offset, cnt_load_val;
  logic [WIDE_W-1:0]   snap_src [N_SNAP];
  logic [DATA_W-1:0]   snap_lo  [N_SNAP];
  logic [DATA_W-1:0]   snap_hi  [N_SNAP];
  logic [ADDR_W-1:0]   snap_addr[N_SNAP];

  assign wr = bus_req_i &  bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  ptp_tc_regs #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_regs (
    .clk_i, .rst_ni, .wr_i(wr), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .en_o(en), .period_o(period), .addend_o(addend), .offset_o(offset),
    .cnt_load_o(cnt_load), .cnt_load_val_o(cnt_load_val)
  );

  ptp_tc_accum #(.ACC_W(DATA_W)) u_accum (
    .clk_i, .rst_ni, .en_i(en), .addend_i(addend), .carry_o(carry)
  );

  ptp_tc_counter #(.CNT_W(WIDE_W), .PERIOD_W(PERIOD_W)) u_counter (
    .clk_i, .rst_ni, .step_i(carry), .period_i(period),
    .load_i(cnt_load), .load_val_i(cnt_load_val), .count_o(raw_count_o)
  );

  assign time_o       = raw_count_o + offset;
  assign snap_src[0]  = raw_count_o;
  assign snap_src[1]  = time_o;
  assign snap_addr[0] = A_CNT_LO;
  assign snap_addr[1] = A_TIME_LO;

  for (genvar g = 0; g < N_SNAP; g++) begin : g_snap
    ptp_tc_snap #(.DATA_W(DATA_W)) u_snap (
      .clk_i, .rst_ni, .sample_i(rd && bus_addr_i == snap_addr[g]),
      .value_i(snap_src[g]), .lo_o(snap_lo[g]), .hi_o(snap_hi[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (bus_addr_i)
        A_CTRL: begin
          bus_rdata_o[EN_BIT]                     = en;
          bus_rdata_o[PERIOD_LSB +: PERIOD_W]     = period;
        end
        A_ADDEND:  bus_rdata_o = addend;
        A_CNT_LO:  bus_rdata_o = snap_lo[0];
        A_CNT_HI:  bus_rdata_o = snap_hi[0];
        A_OFF_LO:  bus_rdata_o = offset[DATA_W-1:0];
        A_OFF_HI:  bus_rdata_o = offset[WIDE_W-1:DATA_W];
        A_TIME_LO: bus_rdata_o = snap_lo[1];
        A_TIME_HI: bus_rdata_o = snap_hi[1];
        default:   bus_rdata_o = '0;
      endcase
    end
  end

  // R9: unmapped reads return zero
  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && bus_addr_i[ADDR_W-1]) |-> bus_rdata_o == '0);
  // R4: disabled and no load means the count holds
  a_r4_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !cnt_load) |=> $stable(raw_count_o));
endmodule

// File: tb/ptp_time_counter_tb.sv
`timescale 1ns/1ps
module ptp_time_counter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] raw_count, time_v;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_time_counter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .raw_count_o(raw_count), .time_o(time_v)
  );

  // behavioural reference
  longint unsigned m_acc, m_cnt, m_off, m_cstage, m_ostage;
  longint unsigned m_add, m_per;
  bit              m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_off = 0; m_cstage = 0; m_ostage = 0;
      m_add = 0; m_per = 0; m_en = 0;
    end else begin
      longint unsigned sum;
      bit carry;
      sum   = m_acc + m_add;
      carry = m_en && (sum >= 64'h1_0000_0000);
      if (m_en) m_acc = sum & 64'hFFFF_FFFF;
      if (req && we && addr == 4'd3) m_cnt = {32'(wdata), m_cstage[31:0]};
      else if (carry) m_cnt = m_cnt + m_per;
      if (req && we) begin
        case (addr)
          4'd0: begin m_en = wdata[0]; m_per = 64'(wdata[15:8]); end
          4'd1: m_add = 64'(wdata);
          4'd2: m_cstage = 64'(wdata);
          4'd4: m_ostage = 64'(wdata);
          4'd5: m_off = {32'(wdata), m_ostage[31:0]};
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string req_tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // R2 R8: per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R8 raw", raw_count, m_cnt);
      check("R7 time", time_v, m_cnt + m_off);
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 d = rdata;
    @(negedge clk); req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      bus_rd(4'(a), d);
      check("R1 reset read", 64'(d), 64'd0);
    end
    check("R1 reset time", time_v, 64'd0);

    // R3: enabled with zero addend never advances
    bus_wr(4'd0, 32'h0000_0801);
    bus_rd(4'd0, d);
    check("R4 ctrl readback", 64'(d), 64'h801);
    t0 = raw_count; idle(20);
    check("R3 zero addend", raw_count, t0);

    // R3: half-scale addend, period 8 -> 80 ns per 20 cycles
    bus_wr(4'd1, 32'h8000_0000);
    idle(2);
    t0 = raw_count; idle(20);
    check("R3 half-scale rate", raw_count - t0, 64'd80);

    // R8: varied addends, period changes, checked by model each cycle
    bus_wr(4'd1, 32'hFFFF_FFF0);
    bus_wr(4'd0, 32'h0000_0501);
    idle(15);
    bus_wr(4'd1, 32'h4000_0000);
    idle(15);
    bus_rd(4'd1, d);
    check("R8 addend readback", 64'(d), 64'h4000_0000);

    // R4: disable holds count
    bus_wr(4'd0, 32'h0000_0500);
    t0 = raw_count; idle(12);
    check("R4 hold disabled", raw_count, t0);

    // R5: staged low, commit on high while disabled
    bus_wr(4'd2, 32'h1234_5678);
    check("R5 low staged only", raw_count, t0);
    bus_wr(4'd3, 32'h0000_000A);
    check("R5 commit", raw_count, 64'h0000_000A_1234_5678);
    bus_rd(4'd2, d);
    check("R6 live low", 64'(d), 64'h1234_5678);
    bus_rd(4'd3, d);
    check("R6 frozen high", 64'(d), 64'hA);

    // R7: offset
    bus_wr(4'd4, 32'h0000_0010);
    bus_wr(4'd5, 32'h0000_0001);
    check("R7 time sum", time_v, 64'h0000_000B_1234_5688);
    bus_rd(4'd6, d);
    check("R6 time low", 64'(d), 64'h1234_5688);
    bus_rd(4'd7, d);
    check("R6 time high", 64'(d), 64'hB);
    bus_rd(4'd5, d);
    check("R7 offset readback", 64'(d), 64'h1);

    // R9: read-only and unmapped addresses
    bus_wr(4'd6, 32'hDEAD_BEEF);
    bus_wr(4'd7, 32'hDEAD_BEEF);
    bus_wr(4'd9, 32'hDEAD_BEEF);
    check("R9 ignored writes", time_v, 64'h0000_000B_1234_5688);
    bus_rd(4'd12, d);
    check("R9 unmapped read", 64'(d), 64'd0);

    // R6: high stays frozen while count crosses the word boundary
    bus_wr(4'd2, 32'hFFFF_FFF0);
    bus_wr(4'd3, 32'h0000_0001);
    bus_wr(4'd1, 32'h8000_0000);
    bus_wr(4'd0, 32'h0000_0801);
    bus_rd(4'd2, d);
    idle(20);
    check("R6 count moved on", raw_count[63:32], 64'h2);
    bus_rd(4'd3, d);
    check("R6 latched high", 64'(d), 64'h1);

    // R5: load wins while counting
    bus_wr(4'd2, 32'h0000_0100);
    bus_wr(4'd1, 32'hFFFF_FFFF);
    idle(2);
    bus_wr(4'd3, 32'h0);
    check("R5 load while running", 64'(raw_count <= 64'h108), 64'd1);
    idle(5);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule